// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire serial EEPROM. It has a clock output, a select, a command/data line toward the memory and a return data line. The host gives a 6-bit word address and pulses a start strobe. The block raises chip select and shifts out a 9-bit read command: two opcode bits `1 1`, a `0`, then the address. It then clocks in 16 data bits, most significant first. To close the access it drops chip select and issues one more clock pulse.

Every half period of the serial clock lasts a fixed number of system clock cycles, which is set by a parameter. The default of 4000 gives 40 us per half period at a 100 MHz system clock. A full access takes 53 half periods. The host sees a busy flag while the access runs. At the end it gets a one-cycle done pulse, and the new word on the data output appears in that same cycle.

Top module: `ser_rom_reader`

## Requirements
- R1: After reset, sk_o, cs_o, di_o, busy_o and done_o are low and data_o is zero.
- R2: A start_i seen while idle raises busy_o and cs_o on the next clock edge.
- R3: The command goes out on di_o, one bit per serial clock pulse, most significant bit first. Its 9 bits are `1,1,0` followed by addr_i[5:0], taken at start. di_o changes only while sk_o is low.
- R4: Each high phase and each low phase of sk_o during an access lasts exactly DLY_CYC system clock cycles, including the first low phase after cs_o rises.
- R5: cs_o stays high without a break for 25 rising edges of sk_o: 9 command bits and then 16 data bits.
- R6: The 16 bits on do_i are taken most significant first, each sampled at the end of an sk_o high phase. They form data_o.
- R7: After the last data bit and one further low phase, cs_o falls at the same edge on which sk_o rises. Exactly one sk_o pulse occurs with cs_o low.
- R8: done_o is a one-cycle pulse. It arrives 53*DLY_CYC cycles after the edge that accepted start, and busy_o falls in the same cycle.
- R9: start_i is ignored while busy_o is high. A second strobe with a different address changes neither the command sent nor the timing.
- R10: data_o changes only in a cycle where done_o is high. It holds the previous word through the whole of a later access.
- R11: di_o is low whenever cs_o is low, and low during the data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Read request strobe |
| addr_i | input | ADDR_W | Word address to read |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | DATA_W | Last word read |
| sk_o | output | 1 | Serial clock to EEPROM |
| cs_o | output | 1 | Chip select to EEPROM |
| di_o | output | 1 | Command line to EEPROM |
| do_i | input | 1 | Data line from EEPROM |

## Verification
A state machine that skips or repeats a phase shows up on the serial pins within one half period. It appears as a high or low run of the wrong length, a missing or extra rising edge under chip select, or a trailing pulse count other than one. A wrong bit counter shifts the command or the data by whole bits. That corrupts the captured command, or data_o at the done pulse, and also moves the done pulse away from 53 half periods after start. Capture logic that loses its hold shows up as data_o drifting during a later access, long before that access ends.

// File: rtl/ser_rom_pkg.sv
package ser_rom_pkg;
  localparam int unsigned PFX_W = 3;
  localparam logic [PFX_W-1:0] RD_PFX = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD_LO,
    ST_CMD_HI,
    ST_DAT_LO,
    ST_DAT_HI,
    ST_TAIL_LO,
    ST_END_HI,
    ST_END_LO
  } st_e;
endpackage

// File: rtl/ser_rom_tick.sv
module ser_rom_tick #(
  parameter int unsigned DLY_CYC = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(DLY_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(DLY_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ser_rom_shift.sv
module ser_rom_shift
  import ser_rom_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              do_i,
  input  logic              commit_i,
  output logic              cmd_msb_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned CMD_W = PFX_W + ADDR_W;

  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] data_q;

  assign cmd_msb_o = cmd_q[CMD_W-1];
  assign data_o    = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmd_q <= '0;
    else if (load_i)   cmd_q <= {RD_PFX, addr_i};
    else if (shift_i)  cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= '0;
    else if (sample_i)  sh_q <= {sh_q[DATA_W-2:0], do_i};
  end

  // host-visible word only moves on completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_q <= '0;
    else if (commit_i)  data_q <= sh_q;
  end
endmodule

// File: rtl/ser_rom_ctrl.sv
module ser_rom_ctrl
  import ser_rom_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic load_o,
  output logic shift_o,
  output logic sample_o,
  output logic commit_o,
  output logic cmd_act_o,
  output logic sk_o,
  output logic cs_o,
  output logic done_o
);
  localparam int unsigned CMD_W = PFX_W + ADDR_W;
  localparam int unsigned BC_N  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int unsigned BC_W  = $clog2(BC_N);

  st_e            st_q;
  logic [BC_W-1:0] bc_q;
  logic           sk_q, cs_q, act_q, done_q;
  logic           last_bit;

  assign last_bit  = (bc_q == '0);
  assign busy_o    = (st_q != ST_IDLE);
  assign load_o    = (st_q == ST_IDLE) && start_i;
  assign shift_o   = (st_q == ST_CMD_HI) && tick_i && !last_bit;
  assign sample_o  = (st_q == ST_DAT_HI) && tick_i;
  assign commit_o  = (st_q == ST_END_LO) && tick_i;
  assign cmd_act_o = act_q;
  assign sk_o      = sk_q;
  assign cs_o      = cs_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bc_q   <= '0;
      sk_q   <= 1'b0;
      cs_q   <= 1'b0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= commit_o;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_CMD_LO;
          cs_q  <= 1'b1;
          act_q <= 1'b1;
          bc_q  <= BC_W'(CMD_W - 1);
        end
        ST_CMD_LO: if (tick_i) begin
          st_q <= ST_CMD_HI;
          sk_q <= 1'b1;
        end
        ST_CMD_HI: if (tick_i) begin
          sk_q <= 1'b0;
          if (last_bit) begin
            st_q  <= ST_DAT_LO;
            act_q <= 1'b0;
            bc_q  <= BC_W'(DATA_W - 1);
          end else begin
            st_q <= ST_CMD_LO;
            bc_q <= bc_q - 1'b1;
          end
        end
        ST_DAT_LO: if (tick_i) begin
          st_q <= ST_DAT_HI;
          sk_q <= 1'b1;
        end
        ST_DAT_HI: if (tick_i) begin
          sk_q <= 1'b0;
          if (last_bit) st_q <= ST_TAIL_LO;
          else begin
            st_q <= ST_DAT_LO;
            bc_q <= bc_q - 1'b1;
          end
        end
        ST_TAIL_LO: if (tick_i) begin
          // deselect and trailing pulse begin together
          st_q <= ST_END_HI;
          cs_q <= 1'b0;
          sk_q <= 1'b1;
        end
        ST_END_HI: if (tick_i) begin
          st_q <= ST_END_LO;
          sk_q <= 1'b0;
        end
        ST_END_LO: if (tick_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ser_rom_reader.sv
module ser_rom_reader #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned DLY_CYC = 4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sk_o,
  output logic              cs_o,
  output logic              di_o,
  input  logic              do_i
);
  logic tick, load, shift, sample, commit, cmd_act, cmd_msb;

  ser_rom_tick #(.DLY_CYC(DLY_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_o),
    .tick_o (tick)
  );

  ser_rom_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .tick_i    (tick),
    .busy_o    (busy_o),
    .load_o    (load),
    .shift_o   (shift),
    .sample_o  (sample),
    .commit_o  (commit),
    .cmd_act_o (cmd_act),
    .sk_o      (sk_o),
    .cs_o      (cs_o),
    .done_o    (done_o)
  );

  ser_rom_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .addr_i    (addr_i),
    .shift_i   (shift),
    .sample_i  (sample),
    .do_i      (do_i),
    .commit_i  (commit),
    .cmd_msb_o (cmd_msb),
    .data_o    (data_o)
  );

  assign di_o = cmd_act & cmd_msb;
endmodule

// File: rtl/ser_rom_chk.sv
module ser_rom_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] data_o,
  input logic              sk_o,
  input logic              cs_o,
  input logic              di_o
);
  AST_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sk_o && !cs_o)); // R1
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && cs_o)); // R2
  AST_DI_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> $stable(di_o)); // R3
  AST_CS_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> busy_o); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R8
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !$fell(busy_o)) |=> (busy_o || done_o)); // R9
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(data_o)); // R10
  AST_DI_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !di_o); // R11
endmodule

bind ser_rom_reader ser_rom_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .data_o  (data_o),
  .sk_o    (sk_o),
  .cs_o    (cs_o),
  .di_o    (di_o)
);

// File: tb/sim_ser_rom_reader.sv
module sim_ser_rom_reader;
  localparam int D     = 3;
  localparam int T_ACC = 53 * D;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        busy_o, done_o, sk_o, cs_o, di_o;
  logic [15:0] data_o;
  logic        eep_do = 1'b0;

  ser_rom_reader #(.ADDR_W(6), .DATA_W(16), .DLY_CYC(D)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done_o), .data_o(data_o),
    .sk_o(sk_o), .cs_o(cs_o), .di_o(di_o), .do_i(eep_do)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // EEPROM model and pin monitor, sampled at falling edge
  int nb = 0, trail = 0, wbad = 0, dibad = 0, hi_cnt = 0, lo_cnt = 0;
  logic        sk_p = 1'b0;
  logic [8:0]  cmd_cap = '0;
  logic [15:0] cur_word = '0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      sk_p = 1'b0; hi_cnt = 0; lo_cnt = 0;
    end else begin
      if (!cs_o && di_o) dibad++;
      if (cs_o && nb >= 9 && !sk_o && di_o) dibad++;
      if (sk_o && !sk_p) begin
        if (lo_cnt != D) wbad++;
        if (cs_o) begin
          if (nb < 9) cmd_cap = {cmd_cap[7:0], di_o};
          else if (nb < 25) eep_do = cur_word[24 - nb];
          nb++;
        end else trail++;
        hi_cnt = 1;
      end else if (sk_o) hi_cnt++;
      if (!sk_o && sk_p && hi_cnt != D) wbad++;
      if (!busy_o || sk_o) lo_cnt = 0;
      else lo_cnt++;
      sk_p = sk_o;
    end
  end

  logic [15:0] prev_word = '0;

  task automatic run_read(input logic [5:0] a, input logic [15:0] w, input int poke);
    int cyc;
    nb = 0; trail = 0; wbad = 0; dibad = 0; cmd_cap = '0; cur_word = w;
    @(negedge clk);
    addr_i = a; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o && cs_o, "R2 busy/cs after start", {busy_o, cs_o}, 2'b11);
    cyc = 0;
    while (!done_o && cyc < T_ACC + 20) begin
      @(negedge clk);
      cyc++;
      if (poke > 0 && cyc == poke) begin addr_i = ~a; start_i = 1'b1; end
      if (poke > 0 && cyc == poke + 1) start_i = 1'b0;
      if (cyc == 60) check(data_o == prev_word, "R10 data held mid-access", data_o, prev_word);
    end
    check(cyc == T_ACC, "R8 done latency", cyc, T_ACC);
    check(!busy_o, "R8 busy low at done", busy_o, 0);
    check(cmd_cap == {3'b110, a}, "R3 command bits", cmd_cap, {3'b110, a});
    check(nb == 25, "R5 pulses under cs", nb, 25);
    check(trail == 1, "R7 trailing pulse", trail, 1);
    check(wbad == 0, "R4 phase widths", wbad, 0);
    check(dibad == 0, "R11 di quiet", dibad, 0);
    check(data_o == w, "R6 data word", data_o, w);
    @(negedge clk);
    check(!done_o && !busy_o, "R8 done one cycle", done_o, 0);
    prev_word = w;
  endtask

  localparam logic [21:0] VEC [6] = '{
    {6'd0,  16'h0000}, {6'd63, 16'hFFFF}, {6'd21, 16'hA5A5},
    {6'd42, 16'h5A5A}, {6'd1,  16'h8001}, {6'd32, 16'h7FFE}
  };

  initial begin
    repeat (3) @(negedge clk);
    check({sk_o, cs_o, di_o, busy_o, done_o} == 5'b0, "R1 pins in reset",
          {sk_o, cs_o, di_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(data_o == 16'h0 && !busy_o && !cs_o, "R1 state after reset", data_o, 0);
    for (int i = 0; i < 6; i++) run_read(VEC[i][21:16], VEC[i][15:0], 0);
    // R9: second strobe with other address mid-access
    run_read(6'd5, 16'h1234, 40);
    run_read(6'd9, 16'hC3C3, 2);
    // R10: data holds while idle
    repeat (10) @(negedge clk);
    check(data_o == 16'hC3C3, "R10 data held idle", data_o, 16'hC3C3);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog act=%0d exp=%0d", wd, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule